// File: doc/BRIEF.md
# Page-Burst Controller for an Asynchronous Byte-Wide SRAM

This block sits between a synchronous host and an asynchronous SRAM with an 8-bit data bus. The host issues single-byte writes and reads, and reads of 1 to 16 consecutive bytes. The controller produces the two chip selects, the write strobe, the output enable and the address. It also drives the data bus through separate output, output-enable and input lanes, so the tri-state buffer can sit at the chip pad. Read bytes come back on a valid/ready handshake, one byte per beat.

Every analog timing limit of the memory is met by a parameter that gives a whole number of clock cycles. There is one parameter each for the read beat length, the write strobe width, the data hold after the strobe and the bus turnaround. The defaults fit a 100 MHz clock and an 85 ns part.

During a multi-byte read the chip stays selected and the upper address bits stay fixed. Only the word-within-page bits advance, which keeps the memory in its low-current page mode. A read that runs past the end of a 16-word page is split into two segments. The chip is deselected between the two segments, and the second segment reopens at word 0 of the next page. When no request is in progress, the chip is deselected and sits in standby.

Top module: `sram_page_ctrl`

## Requirements
- R1: After reset, the chip is deselected (`sram_ce1_n`=1, `sram_ce2`=0), `sram_we_n`=1, `sram_oe_n`=1, `sram_dq_oe`=0, `req_ready`=1 and `rsp_valid`=0.
- R2: A write (`req_write`=1) stores `req_wdata` at `req_addr`. For the write, `sram_we_n` is low for exactly WE_CYC cycles. While it is low, the chip is selected, `sram_oe_n` is high and the data driver is on. The driver stays on for HOLD_CYC cycles after `sram_we_n` rises.
- R3: A read returns the stored byte. Each read beat holds its address with `sram_oe_n` low for at least RD_CYC cycles before the data is captured.
- R4: A read with `req_len`=L (the count minus one, 0 to 15) returns L+1 bytes from ascending addresses. While the read stays in one page, the chip stays selected and address bits above the low 4 stay constant.
- R5: When a read would cross a 16-word page boundary, the chip is deselected for at least TURN_CYC cycles. The read then continues at word 0 of the next page, so the chip is selected once per page touched.
- R6: `rsp_valid` and `rsp_data` stay stable until `rsp_ready` is high. A stalled read holds its current beat and loses no byte.
- R7: The controller never drives the bus while `sram_oe_n` is low. It turns on its driver no sooner than TURN_CYC cycles after `sram_oe_n` rises.
- R8: `req_ready` is high only when no request is in progress. At those times the chip is deselected (standby).
- R9: A read that runs past the top address wraps to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write one byte, 0 = read |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | WORD_BITS | Read byte count minus one |
| req_wdata | input | DATA_W | Write byte |
| rsp_valid | output | 1 | Read byte available |
| rsp_ready | input | 1 | Host takes read byte |
| rsp_data | output | DATA_W | Read byte |
| sram_addr | output | ADDR_W | Memory address |
| sram_ce1_n | output | 1 | Active-low chip select |
| sram_ce2 | output | 1 | Active-high chip select |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_dq_out | output | DATA_W | Data driven to memory |
| sram_dq_oe | output | 1 | Enable for the data driver |
| sram_dq_in | input | DATA_W | Data read from the bus |

## Verification
The assertions assume that the memory never drives the bus unless it is selected with `sram_oe_n` low and `sram_we_n` high. They also assume that `rsp_ready` may change at any cycle. The bench's memory model enforces the first assumption by driving only under that condition. Its data becomes valid only 85 ns after the last address or control change, and is a poison value before that. The stimulus keeps requests legal (`req_len` within its field). Its host stalls responses on a fixed pattern, which exercises the handshake without ever breaking it.

// File: rtl/sram_page_ctrl.sv
`timescale 1ns/1ps
module sram_page_ctrl #(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 8,
  parameter int WORD_BITS = 4,
  parameter int RD_CYC    = 9,
  parameter int WE_CYC    = 5,
  parameter int HOLD_CYC  = 1,
  parameter int TURN_CYC  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [WORD_BITS-1:0] req_len,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [DATA_W-1:0]    rsp_data,
  output logic [ADDR_W-1:0]    sram_addr,
  output logic                 sram_ce1_n,
  output logic                 sram_ce2,
  output logic                 sram_we_n,
  output logic                 sram_oe_n,
  output logic [DATA_W-1:0]    sram_dq_out,
  output logic                 sram_dq_oe,
  input  logic [DATA_W-1:0]    sram_dq_in
);

  localparam int MAX_RW = (RD_CYC > WE_CYC) ? RD_CYC : WE_CYC;
  localparam int MAX_HT = (HOLD_CYC > TURN_CYC) ? HOLD_CYC : TURN_CYC;
  localparam int MAX_C  = (MAX_RW > MAX_HT) ? MAX_RW : MAX_HT;
  localparam int CNT_W  = $clog2(MAX_C + 1);
  localparam int REM_W  = WORD_BITS + 1;
  localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WE_LAST   = CNT_W'(WE_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(TURN_CYC - 1);

  typedef enum logic [2:0] {S_IDLE, S_WR, S_WH, S_RD, S_REL} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [REM_W-1:0]  rem;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;

  logic beat_end, slot_free, take, page_end;

  assign beat_end  = (st == S_RD) && (cnt == RD_LAST);
  assign slot_free = !rsp_valid || rsp_ready;
  assign take      = beat_end && slot_free;
  assign page_end  = (addr[WORD_BITS-1:0] == '1);

  assign req_ready   = (st == S_IDLE);
  assign sram_addr   = addr;
  assign sram_ce1_n  = !(st == S_WR || st == S_WH || st == S_RD);
  assign sram_ce2    = !sram_ce1_n;
  assign sram_we_n   = (st != S_WR);
  assign sram_oe_n   = (st != S_RD);
  assign sram_dq_oe  = (st == S_WR) || (st == S_WH);
  assign sram_dq_out = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      rem   <= '0;
      addr  <= '0;
      wdata <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          addr <= req_addr;
          cnt  <= '0;
          if (req_write) begin
            wdata <= req_wdata;
            st    <= S_WR;
          end else begin
            rem <= {1'b0, req_len} + REM_W'(1);
            st  <= S_RD;
          end
        end
        S_WR: if (cnt == WE_LAST) begin
          cnt <= '0;
          st  <= S_WH;
        end else cnt <= cnt + 1'b1;
        S_WH: if (cnt == HOLD_LAST) begin
          cnt <= '0;
          st  <= S_IDLE;
        end else cnt <= cnt + 1'b1;
        S_RD: if (!beat_end) cnt <= cnt + 1'b1;
        else if (slot_free) begin
          cnt  <= '0;
          rem  <= rem - 1'b1;
          addr <= addr + 1'b1;
          if (rem == REM_W'(1) || page_end) st <= S_REL;
        end
        S_REL: if (cnt == TURN_LAST) begin
          cnt <= '0;
          st  <= (rem != '0) ? S_RD : S_IDLE;
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (take) begin
      rsp_valid <= 1'b1;
      rsp_data  <= sram_dq_in;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

module sram_page_ctrl_chk #(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 8,
  parameter int WORD_BITS = 4,
  parameter int RD_CYC    = 9,
  parameter int WE_CYC    = 5,
  parameter int TURN_CYC  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_ce1_n,
  input logic              sram_ce2,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic              sram_dq_oe
);

  logic [15:0] w_cnt, rel_cnt, h_cnt;
  logic [ADDR_W-1:0] last_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_cnt     <= '0;
      rel_cnt   <= '1;
      h_cnt     <= '0;
      last_addr <= '0;
    end else begin
      w_cnt     <= !sram_we_n ? ((w_cnt == '1) ? w_cnt : w_cnt + 1'b1) : '0;
      rel_cnt   <= !sram_oe_n ? '0 : ((rel_cnt == '1) ? rel_cnt : rel_cnt + 1'b1);
      last_addr <= sram_addr;
      if (sram_oe_n) h_cnt <= '0;
      else if (h_cnt != '0 && sram_addr != last_addr) h_cnt <= 16'd1;
      else if (h_cnt != '1) h_cnt <= h_cnt + 1'b1;
    end
  end

  assert_idle_standby_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce1_n && !sram_ce2));

  assert_write_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (sram_oe_n && !sram_ce1_n && sram_ce2 && sram_dq_oe));

  assert_we_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (w_cnt >= 16'(WE_CYC)));

  assert_data_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> sram_dq_oe);

  assert_no_drive_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n);

  assert_turnaround_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> (rel_cnt >= 16'(TURN_CYC)));

  assert_beat_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cnt != '0 && (sram_oe_n || sram_addr != last_addr)) |-> (h_cnt >= 16'(RD_CYC)));

  assert_page_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_oe_n && !$past(sram_oe_n)) |->
      (sram_addr[ADDR_W-1:WORD_BITS] == $past(sram_addr[ADDR_W-1:WORD_BITS])));

  assert_rsp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

endmodule

bind sram_page_ctrl sram_page_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_BITS(WORD_BITS),
  .RD_CYC(RD_CYC), .WE_CYC(WE_CYC), .TURN_CYC(TURN_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_data(rsp_data), .sram_addr(sram_addr),
  .sram_ce1_n(sram_ce1_n), .sram_ce2(sram_ce2), .sram_we_n(sram_we_n),
  .sram_oe_n(sram_oe_n), .sram_dq_oe(sram_dq_oe)
);

// File: tb/sim_sram_page_ctrl.sv
`timescale 1ns/1ps
module sim_sram_page_ctrl;
  localparam int AW = 18;
  localparam int TURN = 2;
  localparam logic [7:0] POISON = 8'hE7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [3:0] req_len = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid, sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [7:0] rsp_data, sram_dq_out;
  logic [7:0] sram_dq_in = 8'h00;
  logic [AW-1:0] sram_addr;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  sram_page_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .sram_addr(sram_addr), .sram_ce1_n(sram_ce1_n), .sram_ce2(sram_ce2),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_dq_out(sram_dq_out),
    .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  function automatic logic [7:0] fill(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {6'b0, a[17:16]} ^ 8'h3C;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // memory model
  logic [7:0] smem [logic [AW-1:0]];
  logic [7:0] ref_m [logic [AW-1:0]];
  logic model_drv;
  time t_chg = 0;
  logic wp = 1'b0;
  logic [AW-1:0] wa;
  logic [7:0] wd;
  int conflicts = 0;

  assign model_drv = !sram_ce1_n && sram_ce2 && sram_we_n && !sram_oe_n;

  always @(sram_addr or sram_oe_n or sram_ce1_n or sram_ce2) t_chg = $time;

  always @(negedge clk) begin
    if (model_drv && sram_dq_oe) conflicts++;
    if (model_drv && ($time - t_chg) >= 85)
      sram_dq_in = smem.exists(sram_addr) ? smem[sram_addr] : fill(sram_addr);
    else
      sram_dq_in = POISON;
  end

  always @(posedge clk) begin
    if (!sram_ce1_n && sram_ce2 && !sram_we_n) begin
      wa = sram_addr;
      wd = sram_dq_oe ? sram_dq_out : POISON;
      wp = 1'b1;
    end else if (wp && sram_we_n) begin
      smem[wa] = wd;
      wp = 1'b0;
    end
  end

  // timing monitors
  time t_wf = 0, t_dqon = 0, t_off = 0, t_ceup = 0;
  bit wf_seen = 0, off_seen = 0;
  int ce_rises = 0;
  bit in_read = 0;
  time min_gap = 0;

  always @(negedge sram_we_n) if (rst_n) begin t_wf = $time; wf_seen = 1; end
  always @(posedge sram_dq_oe) if (rst_n) begin
    t_dqon = $time;
    if (off_seen) chk(($time - t_off) >= 15, "R7 bus release before drive (ns)",
                      32'($time - t_off), 15);
  end
  always @(negedge model_drv) begin t_off = $time; off_seen = 1; end
  always @(posedge sram_we_n) if (rst_n && wf_seen) begin
    chk(($time - t_wf) >= 50, "R2 WE low width (ns)", 32'($time - t_wf), 50);
    chk(($time - t_dqon) >= 40, "R2 data setup before WE rise (ns)", 32'($time - t_dqon), 40);
    wf_seen = 0;
  end
  always @(posedge sram_ce1_n) if (rst_n) begin t_ceup = $time; ce_rises++; end
  always @(negedge sram_ce1_n) if (in_read && ($time - t_ceup) < min_gap) min_gap = $time - t_ceup;

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [3:0] len, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_len = len; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (!req_ready && n < 1000) begin @(negedge clk); n++; end
    chk(req_ready && sram_ce1_n && !sram_ce2, tag, {sram_ce1_n, sram_ce2}, 2'b10);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d);
    issue(1'b1, a, 4'd0, d);
    chk(!req_ready, "R8 busy during write", req_ready, 0);
    wait_idle("R8 standby after write");
    ref_m[a] = d;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input int n, input bit stall, input string tag);
    int got = 0, k = 0, r0, segs;
    bit hold_pend = 0;
    logic [7:0] hold_d = '0;
    r0 = ce_rises;
    segs = (int'(a[3:0]) + n - 1) / 16 + 1;
    issue(1'b0, a, 4'(n - 1), 8'h00);
    in_read = 1; min_gap = 1000000;
    while (got < n && k < 5000) begin
      if (hold_pend)
        chk(rsp_valid && rsp_data == hold_d, "R6 response held while stalled", rsp_data, hold_d);
      rsp_ready = stall ? (k % 3 == 2) : 1'b1;
      k++;
      hold_pend = rsp_valid && !rsp_ready;
      hold_d = rsp_data;
      if (rsp_valid && rsp_ready) begin
        logic [AW-1:0] ea;
        logic [7:0] ev;
        ea = a + AW'(got);
        ev = ref_m.exists(ea) ? ref_m[ea] : fill(ea);
        chk(rsp_data == ev, tag, rsp_data, ev);
        got++;
      end
      @(negedge clk);
    end
    rsp_ready = 1'b0;
    chk(got == n, "R4 byte count", got, n);
    wait_idle("R8 standby after read");
    chk(ce_rises - r0 == segs, "R5 chip-select openings per read", ce_rises - r0, segs);
    if (segs > 1) chk(min_gap >= TURN * 10, "R5 deselect gap between pages (ns)", 32'(min_gap), TURN * 10);
    in_read = 0;
  endtask

  task automatic t_reset();
    chk(sram_ce1_n && !sram_ce2, "R1 deselected at reset", {sram_ce1_n, sram_ce2}, 2'b10);
    chk(sram_we_n && sram_oe_n, "R1 strobes high at reset", {sram_we_n, sram_oe_n}, 2'b11);
    chk(!sram_dq_oe, "R1 driver off at reset", sram_dq_oe, 0);
    chk(req_ready && !rsp_valid, "R1 ready, no response at reset", {req_ready, rsp_valid}, 2'b10);
  endtask

  task automatic t_single();
    do_write(18'h00010, 8'hA5);
    do_write(18'h12345, 8'h5A);
    do_write(18'h3FFFF, 8'hC3);
    do_read(18'h00010, 1, 0, "R3 single read");
    do_read(18'h12345, 1, 0, "R3 single read");
    do_read(18'h3FFFF, 1, 0, "R3 single read");
    do_read(18'h00777, 1, 0, "R3 read of unwritten byte");
  endtask

  task automatic t_page_burst();
    for (int i = 0; i < 16; i++) do_write(18'h01000 + AW'(i), 8'(8'h80 + i));
    do_read(18'h01000, 16, 0, "R4 full page burst");
    do_read(18'h01003, 5, 0, "R4 short burst inside page");
  endtask

  task automatic t_split();
    for (int i = 0; i < 8; i++) do_write(18'h0220C + AW'(i), 8'(8'h40 + 3 * i));
    do_read(18'h0220C, 8, 0, "R5 burst split across pages");
    do_read(18'h0221F, 16, 0, "R5 burst starting on last word");
  endtask

  task automatic t_wrap();
    do_write(18'h00000, 8'h11);
    do_write(18'h00001, 8'h22);
    do_read(18'h3FFFE, 4, 0, "R9 burst wraps past top address");
  endtask

  task automatic t_stall();
    do_read(18'h01004, 9, 1, "R6 stalled burst data");
    do_read(18'h0220E, 5, 1, "R6 stalled split burst data");
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_single();
    t_page_burst();
    t_split();
    t_wrap();
    t_stall();
    do_write(18'h01002, 8'h9E);
    do_read(18'h01000, 4, 0, "R2 rewrite visible in burst");
    chk(conflicts == 0, "R7 bus driven by both sides (cycles)", conflicts, 0);
    finish_up();
  end
endmodule